// File: doc/BRIEF.md
# Divided Down-Count Local Timer

This block is a per-core countdown timer. A bus clock drives it through a prescaler that divides by a power of two. Software loads a start value, and the counter decrements once per prescaled tick. When the count goes from one to zero, the block sends a single-cycle expiry strobe to the interrupt vector logic beside it. That logic owns the mode bit, which picks one of two behaviours: a one-shot count that parks at zero, or a periodic count that reloads the start value and keeps running.

The divide setting comes from three bits of a four-bit configuration word. The timer captures a new setting straight away, but the running count only uses it from the next load or reload, so a period already under way keeps its length. Three things stop the count: writing a start value of zero, a halt pulse, or a software-disable of the controller. While the controller is enabled and the mode is periodic, a rise of the enable input restarts the count from the stored start value.

Top module: `tick_timer`

## Requirements
- R1: After reset the current count is 0, the strobe is low, and the stored divide code is 0, so the first load with no configuration write divides by 2.
- R2: The divide code is {cfg_val[3], cfg_val[1], cfg_val[0]}. Codes 0 to 6 divide by 2, 4, 8, 16, 32, 64 and 128, and code 7 divides by 1. Bit 2 has no effect.
- R3: A write of a nonzero start value N while enabled shows N on the current count in the next cycle. The count then falls by one every D bus clocks, where D is the divide in force at that load.
- R4: A write of start value 0 stops the timer. The current count reads 0 from the next cycle, and no strobe follows.
- R5: In one-shot mode (periodic = 0) the count reaches 0 N*D cycles after the load, strobes once, and stays at 0.
- R6: In periodic mode (periodic = 1), the cycle in which the count would reach zero instead shows the start value again, with the strobe high. The timer strobes every N*D cycles.
- R7: The strobe is high for exactly the cycle after the count leaves the value 1, and in no other cycle.
- R8: A divide configuration write while the timer runs leaves the current period unchanged. The new divide applies from the next load or periodic reload.
- R9: While enable is low, the count reads 0, and a start value written then is stored but does not start the timer. A rise of enable restarts the count from the stored value if the mode is periodic and that value is nonzero. In one-shot mode the count stays 0.
- R10: A halt pulse stops the timer, and the count reads 0 from the next cycle.
- R11: The current count never exceeds the stored start value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller software-enable; low stops the timer |
| halt | input | 1 | One-cycle pulse that stops the timer |
| periodic | input | 1 | Mode from the vector entry: 1 periodic, 0 one-shot |
| init_wr | input | 1 | Start-value write strobe |
| init_val | input | CNT_W | Start value |
| cfg_wr | input | 1 | Divide configuration write strobe |
| cfg_val | input | 4 | Divide configuration word (bits 3, 1, 0 used) |
| cur_count | output | CNT_W | Current count |
| fire | output | 1 | One-cycle expiry strobe |

## Verification
The assertions assume that every input is synchronous to clk, and that halt, init_wr and cfg_wr are pulses rather than levels that sit in sequence with a half-written value. The reload and one-shot properties also assume the mode bit is steady in the cycle the count leaves 1. The stimulus changes every input only on the falling clock edge and issues at most one register write per cycle. It leaves periodic fixed for the whole of each countdown, except in the enable-restart case, where it changes only while the timer is stopped.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    localparam int CFG_W   = 4;
    localparam int CODE_W  = 3;
    localparam int SHIFT_W = 3;
    localparam int PRE_W   = (1 << SHIFT_W) - 1;

    // code 7 selects divide-by-1; codes 0..6 select 2^(code+1)
    function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [CODE_W-1:0] code);
        return (code == CODE_W'(7)) ? SHIFT_W'(0) : SHIFT_W'(code + CODE_W'(1));
    endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import tick_timer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [SHIFT_W-1:0] new_shift,
    output logic               tick
);
    typedef struct packed {
        logic [PRE_W-1:0]   cnt;
        logic [SHIFT_W-1:0] shift;
    } pre_t;

    pre_t s_d, s_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = ~({PRE_W{1'b1}} << s_q.shift);
        tick  = (s_q.cnt == limit);
        s_d   = s_q;
        if (load) begin
            s_d.cnt   = '0;
            s_d.shift = new_shift;
        end else if (tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_SHIFT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(s_q.shift)); // R8
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             halt,
    input  logic             periodic,
    input  logic             init_wr,
    input  logic [CNT_W-1:0] init_val,
    input  logic             tick,
    output logic             load,
    output logic [CNT_W-1:0] cur_count,
    output logic             fire
);
    typedef struct packed {
        logic [CNT_W-1:0] cur;
        logic [CNT_W-1:0] init;
        logic             running;
        logic             en_prev;
        logic             fire;
    } cnt_t;

    cnt_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.fire    = 1'b0;
        s_d.en_prev = enable;
        load        = 1'b0;
        if (init_wr) s_d.init = init_val;

        if (!enable || halt) begin
            s_d.running = 1'b0;
            s_d.cur     = '0;
        end else if (init_wr) begin
            if (init_val == '0) begin
                s_d.running = 1'b0;
                s_d.cur     = '0;
            end else begin
                s_d.running = 1'b1;
                s_d.cur     = init_val;
                load        = 1'b1;
            end
        end else if (!s_q.en_prev && periodic && (s_q.init != '0)) begin
            s_d.running = 1'b1;
            s_d.cur     = s_q.init;
            load        = 1'b1;
        end else if (s_q.running && tick) begin
            if (s_q.cur == CNT_W'(1)) begin
                s_d.fire = 1'b1;
                if (periodic) begin
                    s_d.cur = s_q.init;
                    load    = 1'b1;
                end else begin
                    s_d.running = 1'b0;
                    s_d.cur     = '0;
                end
            end else begin
                s_d.cur = s_q.cur - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_count = s_q.cur;
    assign fire      = s_q.fire;

    AST_CUR_LE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cur <= s_q.init); // R11
    AST_FIRE_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fire |-> ($past(s_q.cur) == CNT_W'(1))); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.running |-> (s_q.cur == '0)); // R5
    AST_DISABLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!s_q.running && s_q.cur == '0)); // R9
    AST_HALT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (s_q.cur == '0)); // R10
    AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && init_wr && init_val == '0) |=> !s_q.running); // R4
    AST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !halt && init_wr && init_val != '0) |=> (s_q.cur == $past(init_val))); // R3
    AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !halt && !init_wr && s_q.en_prev && s_q.running && tick
         && s_q.cur == CNT_W'(1) && !periodic) |=> (s_q.fire && s_q.cur == '0)); // R5
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !halt && !init_wr && s_q.en_prev && s_q.running && tick
         && s_q.cur == CNT_W'(1) && periodic) |=> (s_q.fire && s_q.cur == $past(s_q.init))); // R6
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             halt,
    input  logic             periodic,
    input  logic             init_wr,
    input  logic [CNT_W-1:0] init_val,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_val,
    output logic [CNT_W-1:0] cur_count,
    output logic             fire
);
    logic [CODE_W-1:0] code_d, code_q;
    logic              load;
    logic              tick;
    logic              unused_cfg_bit;

    assign unused_cfg_bit = cfg_val[2];

    always_comb begin
        code_d = code_q;
        if (cfg_wr) code_d = {cfg_val[3], cfg_val[1], cfg_val[0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    tick_prescaler i_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .new_shift (code_to_shift(code_q)),
        .tick      (tick)
    );

    tick_down_counter #(.CNT_W(CNT_W)) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .halt      (halt),
        .periodic  (periodic),
        .init_wr   (init_wr),
        .init_val  (init_val),
        .tick      (tick),
        .load      (load),
        .cur_count (cur_count),
        .fire      (fire)
    );

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(code_q)); // R8
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n, enable, halt, periodic, init_wr, cfg_wr;
    logic [CW-1:0] init_val;
    logic [3:0]    cfg_val;
    logic [CW-1:0] cur_count;
    logic          fire;
    int            checks = 0;
    int            errors = 0;

    always #4 clk = ~clk;

    tick_timer #(.CNT_W(CW)) i_tick_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .halt(halt),
        .periodic(periodic), .init_wr(init_wr), .init_val(init_val),
        .cfg_wr(cfg_wr), .cfg_val(cfg_val), .cur_count(cur_count), .fire(fire)
    );

    task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int div_of(input int code);
        return (code == 7) ? 1 : (2 << code);
    endfunction

    task automatic load_start(input logic [CW-1:0] v);
        init_val = v; init_wr = 1'b1;
        @(negedge clk);
        init_wr = 1'b0;
    endtask

    task automatic write_cfg(input logic [3:0] c);
        cfg_val = c; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_halt;
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        chk("R10 halt clears count", cur_count, 0);
    endtask

    // samples k cycles after the load edge; k = 0 is the first falling edge after it
    task automatic expect_run(input string req, input int v, input int d, input bit per, input int last);
        int p;
        p = v * d;
        for (int k = 0; k <= last; k++) begin
            int ec, ef;
            if (per) begin
                ec = v - (k % p) / d;
                ef = (k > 0 && (k % p) == 0) ? 1 : 0;
            end else begin
                ec = (k < p) ? v - k / d : 0;
                ef = (k == p) ? 1 : 0;
            end
            chk({req, " count"}, cur_count, CW'(ec));
            chk({req, " R7 strobe"}, {31'd0, fire}, CW'(ef));
            chk("R11 count within start", {31'd0, cur_count <= CW'(v)}, 1);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b1; halt = 1'b0; periodic = 1'b0;
        init_wr = 1'b0; cfg_wr = 1'b0; init_val = '0; cfg_val = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset count", cur_count, 0);
        chk("R1 reset strobe", {31'd0, fire}, 0);

        // R1: default divide is 2
        load_start(2);
        expect_run("R1 default divide R3", 2, 2, 1'b0, 6);
        do_halt;

        // R2 R3 R5 R6: sweep every divide code, several counts, both modes
        for (int code = 0; code < 8; code++) begin
            for (int vi = 0; vi < 3; vi++) begin
                for (int per = 0; per < 2; per++) begin
                    int v;
                    logic [2:0] cb;
                    v  = (vi == 0) ? 1 : (vi == 1) ? 3 : 5;
                    cb = 3'(code);
                    write_cfg({cb[2], ~cb[0], cb[1], cb[0]});
                    periodic = per[0];
                    load_start(CW'(v));
                    if (per == 1)
                        expect_run("R2 R3 R6 periodic", v, div_of(code), 1'b1, 2 * v * div_of(code) + 1);
                    else
                        expect_run("R2 R3 R5 one-shot", v, div_of(code), 1'b0, v * div_of(code) + 2);
                    do_halt;
                end
            end
        end

        // R8: divide change mid-period applies only from the reload
        write_cfg(4'b0000);
        periodic = 1'b1;
        load_start(3);
        for (int k = 0; k <= 15; k++) begin
            int ec, ef;
            if (k <= 6) begin
                ec = 3 - (k % 6) / 2;
                ef = (k == 6) ? 1 : 0;
            end else begin
                ec = 3 - ((k - 6) % 3);
                ef = (((k - 6) % 3) == 0) ? 1 : 0;
            end
            chk("R8 deferred divide count", cur_count, CW'(ec));
            chk("R8 deferred divide strobe", {31'd0, fire}, CW'(ef));
            if (k == 2) begin cfg_val = 4'b1011; cfg_wr = 1'b1; end
            if (k == 3) cfg_wr = 1'b0;
            @(negedge clk);
        end
        do_halt;

        // R4: zero write stops a running count
        write_cfg(4'b1011);
        periodic = 1'b0;
        load_start(5);
        @(negedge clk);
        chk("R4 running before stop", cur_count, 4);
        load_start(0);
        for (int k = 0; k < 8; k++) begin
            chk("R4 stopped count", cur_count, 0);
            chk("R4 no strobe", {31'd0, fire}, 0);
            @(negedge clk);
        end

        // R9: disable stops, writes held, periodic restart on enable
        periodic = 1'b1;
        load_start(4);
        enable = 1'b0;
        @(negedge clk);
        chk("R9 disable clears count", cur_count, 0);
        load_start(3);
        for (int k = 0; k < 5; k++) begin
            chk("R9 write while disabled ignored", cur_count, 0);
            chk("R9 no strobe while disabled", {31'd0, fire}, 0);
            @(negedge clk);
        end
        enable = 1'b1;
        @(negedge clk);
        expect_run("R9 periodic restart", 3, 1, 1'b1, 7);
        enable = 1'b0;
        @(negedge clk);
        periodic = 1'b0;
        enable = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            chk("R9 one-shot no restart", cur_count, 0);
            @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule